// File: doc/BRIEF.md
# Layered Configuration Resolver

This block works out the configuration a network controller should actually run with. Three sources feed it. The lowest is a set of strap pins. Their value is captured while reset is held and kept for as long as the block stays out of reset. The middle source is an image read from non-volatile memory through a simple word request/response port. That image is used only when its trailing checksum word matches. The highest source is a runtime write port for the driver. Each of its fields carries its own "override active" bit.

The resolved interface mode, negotiation policy, delay enables, wake enable, LED mode and station address are presented continuously. Three readback views sit beside them: the latched strap value, the memory load status and the effective settings. A valid flag rises once both the strap capture and the memory load are finished.

Top module: `cfg_resolver`

## Requirements
- R1: While `rst_n` is low, `strap_latched` takes `strap_pins` on every clock. After reset is released it holds that value, whatever the pins do. Configuration bit layout, used for straps, image word 0 and `eff_cfg`: bit0 interface mode, bit1 auto-negotiation enable, bit2 transmit delay, bit3 receive delay, bit4 wake enable, bits6:5 LED mode.
- R2: From the first clock after reset release, the loader reads addresses IMG_BASE to IMG_BASE+4 in rising order. It keeps one request outstanding at a time and holds `nvm_req` and `nvm_addr` steady until the cycle in which `nvm_ack` is high. Once the load is done, `nvm_req` stays low.
- R3: `nvm_done` rises after the fifth word is accepted. `nvm_ok` is then high exactly when that word equals the sum, modulo 65536, of the four words before it. Both flags stay low until then.
- R4: While the image is not valid (still loading or failed its checksum), every field without an override comes from the latched strap value, and the station address comes from DEF_ADDR.
- R5: A valid image replaces the strap and default values. Word 0 bits 6:0 give the configuration. Words 1, 2 and 3 give address bits 47:32, 31:16 and 15:0.
- R6: A driver write (`drv_we`) with `drv_keep`=1 sets the override for the field chosen by `drv_field`: 0 to 4 select configuration bits 0 to 4 (taken from data bit 0), 5 selects the LED mode (data bits 1:0), 6 selects the station address (data bits 47:0), and 7 is ignored. From the next cycle the override wins over both lower layers.
- R7: A driver write with `drv_keep`=0 drops that field's override, so the field falls back to the image or strap value from the next cycle.
- R8: `eff_valid` is low during reset and during the memory load. It is high once `nvm_done` is high.
- R9: A warm reset clears all overrides and reloads. With the same pins and image present, it returns the same station address and configuration as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the strap capture window |
| strap_pins | input | 7 | Strap pin levels |
| nvm_req | output | 1 | Word read request |
| nvm_addr | output | ADDR_W | Word address of the request |
| nvm_ack | input | 1 | Response strobe, one cycle per request |
| nvm_rdata | input | 16 | Response data, valid with `nvm_ack` |
| drv_we | input | 1 | Driver write strobe |
| drv_field | input | 3 | Field select |
| drv_keep | input | 1 | 1 = set override, 0 = drop override |
| drv_wdata | input | 48 | Override value |
| strap_latched | output | 7 | Readback of captured straps |
| nvm_done | output | 1 | Memory load finished |
| nvm_ok | output | 1 | Image checksum matched |
| eff_cfg | output | 7 | Resolved configuration |
| eff_addr | output | 48 | Resolved station address |
| eff_valid | output | 1 | Resolved outputs may be used |

## Verification
Wrong internal state shows up in different places. A corrupt load index shows within one response cycle as a wrong `nvm_addr`. A mis-stored image word or a faulty checksum shows in `eff_cfg`, `eff_addr` or `nvm_ok` as soon as `nvm_done` rises. An override bit stuck in the wrong value shows in the cycle after the write that should have changed it. A reference model in the bench is compared with every output on every clock, so any of these is caught in the first cycle it reaches a port.

// File: rtl/cfg_resolver.sv
module cfg_resolver #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IMG_BASE = 8'h10,
  parameter logic [47:0] DEF_ADDR = 48'h02_00_00_00_00_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        strap_pins,
  output logic              nvm_req,
  output logic [ADDR_W-1:0] nvm_addr,
  input  logic              nvm_ack,
  input  logic [15:0]       nvm_rdata,
  input  logic              drv_we,
  input  logic [2:0]        drv_field,
  input  logic              drv_keep,
  input  logic [47:0]       drv_wdata,
  output logic [6:0]        strap_latched,
  output logic              nvm_done,
  output logic              nvm_ok,
  output logic [6:0]        eff_cfg,
  output logic [47:0]       eff_addr,
  output logic              eff_valid
);
  localparam int LAST = 4;

  logic        run, done, ok;
  logic [2:0]  idx;
  logic [15:0] sum;
  logic [6:0]  strap_q, img_cfg, ov_cfg, ov_v;
  logic [47:0] img_addr, ov_addr;
  logic [6:0]  base_cfg;
  logic [47:0] base_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_pins;
      run     <= 1'b0;
      done    <= 1'b0;
      ok      <= 1'b0;
      idx     <= '0;
      sum     <= '0;
      ov_v    <= '0;
    end else begin
      run <= 1'b1;
      if (run && !done && nvm_ack) begin
        case (idx)
          3'd0: img_cfg         <= nvm_rdata[6:0];
          3'd1: img_addr[47:32] <= nvm_rdata;
          3'd2: img_addr[31:16] <= nvm_rdata;
          3'd3: img_addr[15:0]  <= nvm_rdata;
          default: ;
        endcase
        if (idx == 3'(LAST)) begin
          done <= 1'b1;
          ok   <= (sum == nvm_rdata);
        end else begin
          sum <= sum + nvm_rdata;
        end
        idx <= idx + 3'd1;
      end
      if (drv_we && drv_field != 3'd7) begin
        ov_v[drv_field] <= drv_keep;
        if (drv_keep) begin
          case (drv_field)
            3'd5:    ov_cfg[6:5] <= drv_wdata[1:0];
            3'd6:    ov_addr     <= drv_wdata;
            default: ov_cfg[drv_field] <= drv_wdata[0];
          endcase
        end
      end
    end
  end

  assign nvm_req   = run & ~done;
  assign nvm_addr  = IMG_BASE + ADDR_W'(idx);
  assign base_cfg  = ok ? img_cfg : strap_q;
  assign base_addr = ok ? img_addr : DEF_ADDR;

  for (genvar i = 0; i < 5; i++) begin : g_bit
    assign eff_cfg[i] = ov_v[i] ? ov_cfg[i] : base_cfg[i];
  end
  assign eff_cfg[6:5] = ov_v[5] ? ov_cfg[6:5] : base_cfg[6:5];
  assign eff_addr     = ov_v[6] ? ov_addr : base_addr;

  assign strap_latched = strap_q;
  assign nvm_done      = done;
  assign nvm_ok        = ok;
  assign eff_valid     = run & done;
endmodule

// File: rtl/cfg_resolver_chk.sv
module cfg_resolver_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nvm_req,
  input logic [ADDR_W-1:0] nvm_addr,
  input logic              nvm_ack,
  input logic              drv_we,
  input logic [2:0]        drv_field,
  input logic              drv_keep,
  input logic [47:0]       drv_wdata,
  input logic [6:0]        strap_latched,
  input logic              nvm_done,
  input logic              nvm_ok,
  input logic [6:0]        eff_cfg,
  input logic              eff_valid
);
  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_latched));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && !nvm_ack) |=> (nvm_req && $stable(nvm_addr)));
  // R2
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_done |-> !nvm_req);
  // R3
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nvm_done |-> !nvm_ok);
  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_done |=> nvm_done);
  // R6
  wake_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_we && drv_keep && drv_field == 3'd4) |=> (eff_cfg[4] == $past(drv_wdata[0])));
  // R8
  valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_valid == nvm_done);
endmodule

bind cfg_resolver cfg_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cfg_resolver.sv
module sim_cfg_resolver;
  localparam int CLK_P = 10;
  localparam logic [7:0]  BASE = 8'h10;
  localparam logic [47:0] DEFA = 48'h02_00_00_00_00_01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] strap_pins = '0;
  logic nvm_req, nvm_ack = 1'b0;
  logic [7:0] nvm_addr;
  logic [15:0] nvm_rdata = '0;
  logic drv_we = 1'b0, drv_keep = 1'b0;
  logic [2:0] drv_field = '0;
  logic [47:0] drv_wdata = '0;
  logic [6:0] strap_latched, eff_cfg;
  logic nvm_done, nvm_ok, eff_valid;
  logic [47:0] eff_addr;

  cfg_resolver u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_tag = "R8";

  task automatic cmp(string tag, logic [47:0] act, logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  logic [15:0] mem [256];
  int lat = 1, cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin nvm_ack <= 1'b0; cnt <= lat; end
    else if (nvm_ack) begin nvm_ack <= 1'b0; cnt <= lat; end
    else if (nvm_req) begin
      if (cnt == 0) begin nvm_ack <= 1'b1; nvm_rdata <= mem[nvm_addr]; end
      else cnt <= cnt - 1;
    end
  end

  task automatic load_image(logic [6:0] c, logic [47:0] a, bit corrupt);
    logic [15:0] w [5];
    w[0] = {9'd0, c}; w[1] = a[47:32]; w[2] = a[31:16]; w[3] = a[15:0];
    w[4] = w[0] + w[1] + w[2] + w[3] + (corrupt ? 16'd1 : 16'd0);
    for (int i = 0; i < 5; i++) mem[BASE + 8'(i)] = w[i];
  endtask

  // reference model
  bit m_started = 0, m_run = 0, m_done = 0, m_ok = 0;
  int m_idx = 0;
  logic [6:0] m_strap;
  logic [15:0] m_w [5];
  bit m_ov [7];
  logic [47:0] m_ovv [7];

  always @(posedge clk) begin
    m_started <= 1;
    if (!rst_n) begin
      m_strap = strap_pins; m_run = 0; m_done = 0; m_ok = 0; m_idx = 0;
      for (int i = 0; i < 7; i++) m_ov[i] = 0;
    end else begin
      if (m_run && !m_done && nvm_ack) begin
        m_w[m_idx] = nvm_rdata;
        m_idx++;
        if (m_idx == 5) begin
          m_done = 1;
          m_ok = ((m_w[0] + m_w[1] + m_w[2] + m_w[3]) & 16'hFFFF) == m_w[4];
        end
      end
      m_run = 1;
      if (drv_we && drv_field != 3'd7) begin
        m_ov[drv_field] = drv_keep;
        if (drv_keep) m_ovv[drv_field] = drv_wdata;
      end
    end
  end

  function automatic logic [6:0] exp_cfg();
    logic [6:0] b = m_ok ? m_w[0][6:0] : m_strap;
    for (int i = 0; i < 5; i++) if (m_ov[i]) b[i] = m_ovv[i][0];
    if (m_ov[5]) b[6:5] = m_ovv[5][1:0];
    return b;
  endfunction

  function automatic logic [47:0] exp_addr();
    if (m_ov[6]) return m_ovv[6];
    return m_ok ? {m_w[1], m_w[2], m_w[3]} : DEFA;
  endfunction

  always @(negedge clk) begin
    if (m_started) begin
      cmp("R1 strap_latched", 48'(strap_latched), 48'(m_strap));
      cmp("R2 nvm_req", 48'(nvm_req), 48'(m_run && !m_done));
      if (m_run && !m_done) cmp("R2 nvm_addr", 48'(nvm_addr), 48'(BASE + 8'(m_idx)));
      cmp("R3 nvm_done", 48'(nvm_done), 48'(m_done));
      cmp("R3 nvm_ok", 48'(nvm_ok), 48'(m_ok));
      cmp("R8 eff_valid", 48'(eff_valid), 48'(m_run && m_done));
      if (m_run) begin
        cmp({cur_tag, " eff_cfg"}, 48'(eff_cfg), 48'(exp_cfg()));
        cmp({cur_tag, " eff_addr"}, eff_addr, exp_addr());
      end
    end
  end

  task automatic drv(logic [2:0] f, logic k, logic [47:0] d);
    @(negedge clk);
    drv_we = 1; drv_field = f; drv_keep = k; drv_wdata = d;
    @(negedge clk);
    drv_we = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !nvm_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  logic [47:0] first_addr;

  initial begin
    strap_pins = 7'h35;
    load_image(7'h4A, 48'hA1B2_C3D4_E5F6, 0);
    cur_tag = "R4";
    do_reset();
    cmp("R8 eff_valid during load", 48'(eff_valid), 48'd0);
    wait_done();
    cur_tag = "R5";
    cmp("R3 nvm_ok good image", 48'(nvm_ok), 48'd1);
    cmp("R5 eff_cfg from image", 48'(eff_cfg), 48'h4A);
    cmp("R5 eff_addr from image", eff_addr, 48'hA1B2_C3D4_E5F6);
    first_addr = eff_addr;
    strap_pins = 7'h0F;
    repeat (4) @(negedge clk);
    cmp("R1 strap held after reset", 48'(strap_latched), 48'h35);
    cur_tag = "R6";
    drv(3'd4, 1, 48'd1);
    cmp("R6 wake override", 48'(eff_cfg[4]), 48'd1);
    drv(3'd5, 1, 48'd1);
    cmp("R6 led override", 48'(eff_cfg[6:5]), 48'd1);
    drv(3'd6, 1, 48'h0A0B_0C0D_0E0F);
    cmp("R6 addr override", eff_addr, 48'h0A0B_0C0D_0E0F);
    drv(3'd7, 1, 48'hFFFF);
    cmp("R6 field 7 ignored", 48'(eff_cfg), 48'h2A | 48'h10);
    cur_tag = "R7";
    drv(3'd4, 0, 48'd1);
    cmp("R7 wake fallback", 48'(eff_cfg[4]), 48'd0);
    drv(3'd6, 0, 48'd0);
    cmp("R7 addr fallback", eff_addr, 48'hA1B2_C3D4_E5F6);
    cur_tag = "R9";
    strap_pins = 7'h35; lat = 2;
    do_reset();
    wait_done();
    cmp("R9 addr after warm reset", eff_addr, first_addr);
    cmp("R9 cfg after warm reset", 48'(eff_cfg), 48'h4A);
    cur_tag = "R4";
    load_image(7'h11, 48'h1234_5678_9ABC, 1);
    strap_pins = 7'h53; lat = 3;
    do_reset();
    wait_done();
    cmp("R3 nvm_ok bad checksum", 48'(nvm_ok), 48'd0);
    cmp("R4 cfg from strap", 48'(eff_cfg), 48'h53);
    cmp("R4 default addr", eff_addr, DEFA);
    cur_tag = "R6";
    drv(3'd0, 1, 48'd0);
    cmp("R6 mode override on strap", 48'(eff_cfg[0]), 48'd0);
    cur_tag = "R5";
    load_image(7'h7F, 48'hFFFF_FFFF_FFFF, 0);
    lat = 0;
    do_reset();
    wait_done();
    cmp("R3 nvm_ok wraparound sum", 48'(nvm_ok), 48'd1);
    cmp("R5 cfg all ones", 48'(eff_cfg), 48'h7F);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule